// File: doc/BRIEF.md
# Row-Column Bit Interleaver for Rate Matching

This block reorders one coded bit stream of runtime length D (1 to `MAX_LEN`) through a matrix that always has 32 columns. In forward mode, incoming bits fill the matrix row by row. The matrix is padded at its front with dummy positions so that every row is full. The block then reads the matrix out column by column, visiting the columns in a fixed bit-reversed sequence. Each output bit carries a flag that marks the padding, so a later selection stage can discard it. The matrix is held in a single frame buffer. A whole frame is written before any readout starts.

In inverse mode, the receive side feeds back the D real bits in interleaved order, with the padding already removed. The block reserves the padding positions itself and stores each arriving bit in the matrix cell it came from. It then reads the matrix row by row and skips the padding, so the bits come out in their original order. A system with several coded streams uses one instance per stream.

Top module: `sbi_interleaver`

## Requirements
- R1: During and after reset, `idle_o` is 1 and `out_valid_o` and `out_last_o` are 0.
- R2: A forward frame (`inverse_i`=0) emits exactly 32·R bits, where R = ceil(D/32). The first 32·R−D positions in row-major order (row 0, columns 0 up to that count minus 1) are dummies. A dummy is output with `out_dummy_o`=1 and `out_bit_o`=0. All other outputs have `out_dummy_o`=0.
- R3: Forward readout visits column slots 0 to 31 in turn. Slot k reads column c = bit-reverse of the 5-bit value k, which gives the sequence 0,16,8,24,4,20,12,28,2,18,10,26,6,22,14,30,1,17,9,25,5,21,13,29,3,19,11,27,7,23,15,31. Within a column, rows run from 0 to R−1. The non-dummy cell at row r, column c carries input bit number 32·r + c − (32·R − D), counting input bits from 0.
- R4: An inverse frame (`inverse_i`=1) accepts D bits in the order of the forward non-dummy outputs. It emits exactly D bits, all with `out_dummy_o`=0, in the original order. A forward pass followed by an inverse pass therefore returns the input sequence unchanged.
- R5: `out_last_o` is 1 together with the final output bit of a frame and at no other time.
- R6: `out_valid_o` rises in the cycle after the clock edge that accepts the D-th input bit. It then stays 1 in every cycle up to and including the last output.
- R7: `start_i` is ignored while the block is not idle. A start with length 0 or a length above `MAX_LEN` is ignored, and the block stays idle.
- R8: `in_valid_i` has no effect outside the loading phase. During loading, a cycle with `in_valid_i`=0 writes nothing, so the input may contain gaps.
- R9: `idle_o` falls on an accepted start and returns to 1 in the cycle in which the final output bit is presented. No other output bit is presented while `idle_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a frame when the block is idle |
| len_i | input | LEN_W | Stream length D, sampled with an accepted start |
| inverse_i | input | 1 | 0 = forward interleave, 1 = inverse; sampled with an accepted start |
| in_valid_i | input | 1 | Input bit present during loading |
| in_bit_i | input | 1 | Input bit |
| idle_o | output | 1 | Block is ready to accept a start |
| out_valid_o | output | 1 | Output bit present |
| out_bit_o | output | 1 | Output bit |
| out_dummy_o | output | 1 | Output position is padding |
| out_last_o | output | 1 | Final output bit of the frame |

## Verification
Every frame is run forward and then inverse. The inverse input is the forward stream predicted by the bench with the padding removed, so a correct result shows both the permutation and its exact inverse. The lengths cover the main cases of the padding geometry. A length of 44 leaves 20 dummies in row 0. A length of 6148 gives the largest matrix, 193 rows. Exact multiples of 32 have no padding. Length 33 gives 31 dummies. Lengths 1 and 5 give a single row in which most columns are pure padding, which forces the inverse writer to skip whole columns. Random lengths with random input gaps show that the write side stalls correctly. Start and valid pulses during readout, and starts with lengths out of range, must leave the streams untouched.

// File: rtl/sbi_pkg.sv
// Package: shared constants, FSM state type and the column permutation
// for the 32-column row-column bit interleaver.
package sbi_pkg;

    localparam int NCOL  = 32;
    localparam int COL_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_READ = 2'd2
    } sbi_state_e;

    // Column visited in read slot k: the 5-bit reversal of k.
    function automatic logic [COL_W-1:0] col_of_slot(input logic [COL_W-1:0] k);
        return {k[0], k[1], k[2], k[3], k[4]};
    endfunction

endpackage

// File: rtl/sbi_ctrl.sv
// Frame controller: accepts a start while idle (length 1..MAX_LEN only),
// derives the matrix geometry and sequences the load and read phases.
// Assumes the writer and reader traversals report their final position.
module sbi_ctrl
    import sbi_pkg::*;
#(
    parameter int MAX_LEN = 6148,
    parameter int LEN_W   = 13,
    parameter int ROW_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             inverse_i,
    input  logic             in_valid_i,
    input  logic             wr_last_i,
    input  logic             rd_last_i,
    output logic             init_o,
    output logic             wr_step_o,
    output logic             rd_step_o,
    output logic             idle_o,
    output logic [ROW_W-1:0] rows_o,
    output logic [COL_W-1:0] nd_o,
    output logic             cfg_inverse_o,
    output logic [LEN_W-1:0] cfg_len_o
);

    sbi_state_e       state_q;
    logic [LEN_W:0]   len_ext;
    logic             len_ok;

    // Geometry of the requested frame: rows = ceil(D/32), pad = -D mod 32.
    always_comb begin
        len_ext = {1'b0, len_i} + (LEN_W+1)'(NCOL - 1);
        rows_o  = ROW_W'(len_ext >> COL_W);
        nd_o    = COL_W'(COL_W'(0) - len_i[COL_W-1:0]);
        len_ok  = (len_i != '0) && (32'(len_i) <= MAX_LEN);
    end

    assign idle_o    = (state_q == ST_IDLE);
    assign init_o    = idle_o && start_i && len_ok;
    assign wr_step_o = (state_q == ST_LOAD) && in_valid_i;
    assign rd_step_o = (state_q == ST_READ);

    // Phase sequencing and capture of the frame configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            cfg_inverse_o <= 1'b0;
            cfg_len_o     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (init_o) begin
                    state_q       <= ST_LOAD;
                    cfg_inverse_o <= inverse_i;
                    cfg_len_o     <= len_i;
                end
                ST_LOAD: if (wr_step_o && wr_last_i) state_q <= ST_READ;
                ST_READ: if (rd_last_i)              state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbi_trav.sv
// Matrix traversal: walks the R x 32 matrix either row-major or in
// permuted column order, optionally skipping the padding cells (which
// all lie in row 0, columns below the pad count). Configuration is
// latched on init; one position advance per step.
module sbi_trav
    import sbi_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             step_i,
    input  logic             col_order_i,
    input  logic             skip_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic [COL_W-1:0] nd_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             dummy_o,
    output logic             last_o
);

    logic             colord_q;
    logic             skip_q;
    logic [ROW_W-1:0] rows_q;
    logic [COL_W-1:0] nd_q;
    logic [COL_W-1:0] k_q;
    logic [ROW_W-1:0] r_q;
    logic [COL_W-1:0] first_k;
    logic [COL_W-1:0] next_k;

    // A column slot holds at least one visited cell.
    function automatic logic slot_ok(input logic [COL_W-1:0] k, input logic skip,
                                     input logic [ROW_W-1:0] rows, input logic [COL_W-1:0] nd);
        return !skip || (rows != ROW_W'(1)) || (col_of_slot(k) >= nd);
    endfunction

    // First visited row in a column: row 1 when row 0 is skipped padding.
    function automatic logic [ROW_W-1:0] start_row(input logic [COL_W-1:0] k, input logic skip,
                                                   input logic [COL_W-1:0] nd);
        return ROW_W'(skip && (col_of_slot(k) < nd));
    endfunction

    // Lowest usable slot for the configuration being loaded.
    always_comb begin
        first_k = COL_W'(NCOL - 1);
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (slot_ok(COL_W'(i), skip_i, rows_i, nd_i)) first_k = COL_W'(i);
        end
    end

    // Next usable slot after the current one.
    always_comb begin
        next_k = COL_W'(NCOL - 1);
        for (int i = NCOL - 1; i >= 0; i--) begin
            if ((COL_W'(i) > k_q) && slot_ok(COL_W'(i), skip_q, rows_q, nd_q)) next_k = COL_W'(i);
        end
    end

    // Position register: load the start cell or advance one cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colord_q <= 1'b0;
            skip_q   <= 1'b0;
            rows_q   <= ROW_W'(1);
            nd_q     <= '0;
            k_q      <= '0;
            r_q      <= '0;
        end else if (init_i) begin
            colord_q <= col_order_i;
            skip_q   <= skip_i;
            rows_q   <= rows_i;
            nd_q     <= nd_i;
            if (col_order_i) begin
                k_q <= first_k;
                r_q <= start_row(first_k, skip_i, nd_i);
            end else begin
                k_q <= skip_i ? nd_i : '0;
                r_q <= '0;
            end
        end else if (step_i) begin
            if (colord_q) begin
                if (r_q == rows_q - ROW_W'(1)) begin
                    k_q <= next_k;
                    r_q <= start_row(next_k, skip_q, nd_q);
                end else begin
                    r_q <= r_q + ROW_W'(1);
                end
            end else begin
                if (k_q == COL_W'(NCOL - 1)) r_q <= r_q + ROW_W'(1);
                k_q <= k_q + COL_W'(1);
            end
        end
    end

    assign row_o   = r_q;
    assign col_o   = colord_q ? col_of_slot(k_q) : k_q;
    assign dummy_o = (r_q == '0) && (col_o < nd_q);
    assign last_o  = (k_q == COL_W'(NCOL - 1)) && (r_q == rows_q - ROW_W'(1));

endmodule

// File: rtl/sbi_store.sv
// Frame buffer: one 32-bit word per matrix row, single-bit writes and
// registered single-bit reads. Padding cells are never written.
module sbi_store
    import sbi_pkg::*;
#(
    parameter int DEPTH = 193,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [ROW_W-1:0] wr_row_i,
    input  logic [COL_W-1:0] wr_col_i,
    input  logic             wr_bit_i,
    input  logic             re_i,
    input  logic [ROW_W-1:0] rd_row_i,
    input  logic [COL_W-1:0] rd_col_i,
    output logic             rd_bit_o
);

    logic [NCOL-1:0] mem [DEPTH];

    // Bit write into the addressed row word.
    always_ff @(posedge clk) begin
        if (we_i) mem[wr_row_i][wr_col_i] <= wr_bit_i;
    end

    // Registered bit read.
    always_ff @(posedge clk) begin
        if (re_i) rd_bit_o <= mem[rd_row_i][rd_col_i];
    end

endmodule

// File: rtl/sbi_interleaver.sv
// Top: 32-column sub-block bit interleaver with padding at the front.
// Forward mode writes row-major and reads in permuted column order,
// flagging padding; inverse mode writes in permuted column order around
// the padding and reads row-major without it. One bit per cycle each way;
// the full frame is stored before readout begins.
module sbi_interleaver
    import sbi_pkg::*;
#(
    parameter  int MAX_LEN = 6148,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             inverse_i,
    input  logic             in_valid_i,
    input  logic             in_bit_i,
    output logic             idle_o,
    output logic             out_valid_o,
    output logic             out_bit_o,
    output logic             out_dummy_o,
    output logic             out_last_o
);

    localparam int MAX_ROWS = (MAX_LEN + NCOL - 1) / NCOL;
    localparam int ROW_W    = $clog2(MAX_ROWS + 1);

    logic             init;
    logic             wr_step;
    logic             rd_step;
    logic [ROW_W-1:0] rows;
    logic [COL_W-1:0] nd;
    logic             cfg_inverse;
    logic [LEN_W-1:0] cfg_len;
    logic [ROW_W-1:0] wr_row;
    logic [COL_W-1:0] wr_col;
    logic             wr_dummy;
    logic             wr_last;
    logic [ROW_W-1:0] rd_row;
    logic [COL_W-1:0] rd_col;
    logic             rd_dummy;
    logic             rd_last;
    logic             rd_bit;
    logic             out_valid_q;
    logic             out_dummy_q;
    logic             out_last_q;

    sbi_ctrl #(
        .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ROW_W(ROW_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .inverse_i(inverse_i), .in_valid_i(in_valid_i),
        .wr_last_i(wr_last), .rd_last_i(rd_last),
        .init_o(init), .wr_step_o(wr_step), .rd_step_o(rd_step),
        .idle_o(idle_o), .rows_o(rows), .nd_o(nd),
        .cfg_inverse_o(cfg_inverse), .cfg_len_o(cfg_len)
    );

    // Writer: row-major when forward, permuted columns when inverse; never
    // lands on padding.
    sbi_trav #(.ROW_W(ROW_W)) i_wr_trav (
        .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(wr_step),
        .col_order_i(inverse_i), .skip_i(1'b1), .rows_i(rows), .nd_i(nd),
        .row_o(wr_row), .col_o(wr_col), .dummy_o(wr_dummy), .last_o(wr_last)
    );

    // Reader: permuted columns with padding when forward, row-major without
    // padding when inverse.
    sbi_trav #(.ROW_W(ROW_W)) i_rd_trav (
        .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(rd_step),
        .col_order_i(!inverse_i), .skip_i(inverse_i), .rows_i(rows), .nd_i(nd),
        .row_o(rd_row), .col_o(rd_col), .dummy_o(rd_dummy), .last_o(rd_last)
    );

    sbi_store #(.DEPTH(MAX_ROWS), .ROW_W(ROW_W)) i_store (
        .clk(clk), .we_i(wr_step), .wr_row_i(wr_row), .wr_col_i(wr_col),
        .wr_bit_i(in_bit_i), .re_i(rd_step), .rd_row_i(rd_row),
        .rd_col_i(rd_col), .rd_bit_o(rd_bit)
    );

    // Output flags aligned with the registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_dummy_q <= 1'b0;
            out_last_q  <= 1'b0;
        end else begin
            out_valid_q <= rd_step;
            out_dummy_q <= rd_step && rd_dummy;
            out_last_q  <= rd_step && rd_last;
        end
    end

    assign out_valid_o = out_valid_q;
    assign out_dummy_o = out_dummy_q;
    assign out_last_o  = out_last_q;
    assign out_bit_o   = out_valid_q && !out_dummy_q && rd_bit;

endmodule

// File: rtl/sbi_checker.sv
// Checker: protocol and framing properties of the interleaver outputs,
// bound to the top module.
module sbi_checker #(
    parameter int LEN_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_o,
    input logic             out_valid_o,
    input logic             out_bit_o,
    input logic             out_dummy_o,
    input logic             out_last_o,
    input logic             cfg_inverse,
    input logic [LEN_W-1:0] cfg_len
);

    logic [15:0] out_cnt_q;
    logic [15:0] exp_cnt;

    // Count outputs of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           out_cnt_q <= '0;
        else if (out_valid_o) out_cnt_q <= out_last_o ? 16'd0 : out_cnt_q + 16'd1;
    end

    // Expected outputs per frame: D inverse, 32*ceil(D/32) forward.
    assign exp_cnt = cfg_inverse ? 16'(cfg_len)
                                 : 16'(((32'(cfg_len) + 32'd31) >> 5) << 5);

    a_r2_frame_size: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> (out_cnt_q + 16'd1 == exp_cnt));

    a_r3_dummy_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_dummy_o |-> (out_valid_o && !out_bit_o));

    a_r4_inverse_no_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && cfg_inverse) |-> !out_dummy_o);

    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |=> out_valid_o);

    a_r9_busy_while_streaming: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |-> !idle_o);

    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> ($stable(cfg_len) && $stable(cfg_inverse)));

endmodule

bind sbi_interleaver sbi_checker #(.LEN_W(LEN_W)) i_sbi_checker (
    .clk(clk), .rst_n(rst_n), .idle_o(idle_o), .out_valid_o(out_valid_o),
    .out_bit_o(out_bit_o), .out_dummy_o(out_dummy_o), .out_last_o(out_last_o),
    .cfg_inverse(cfg_inverse), .cfg_len(cfg_len)
);

// File: tb/test_sbi_interleaver.sv
// Bench: forward then inverse frames over directed and random lengths,
// compared with a bench model of the permutation.
module test_sbi_interleaver;

    localparam int MAX_LEN = 6148;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int BUF     = 6176;
    localparam int ORDER [32] = '{0,16,8,24,4,20,12,28,2,18,10,26,6,22,14,30,
                                  1,17,9,25,5,21,13,29,3,19,11,27,7,23,15,31};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic             inverse_i = 1'b0;
    logic             in_valid_i = 1'b0;
    logic             in_bit_i = 1'b0;
    logic             idle_o, out_valid_o, out_bit_o, out_dummy_o, out_last_o;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  cyc_last, cyc_first, nout;
    bit  gap_seen, idle_at_last;
    bit  src  [BUF];
    bit  orig [BUF];
    bit  exp_b[BUF];
    bit  exp_d[BUF];
    bit  got_b[BUF];
    bit  got_d[BUF];

    sbi_interleaver #(.MAX_LEN(MAX_LEN)) i_sbi_interleaver (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .inverse_i(inverse_i), .in_valid_i(in_valid_i), .in_bit_i(in_bit_i),
        .idle_o(idle_o), .out_valid_o(out_valid_o), .out_bit_o(out_bit_o),
        .out_dummy_o(out_dummy_o), .out_last_o(out_last_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Forward model: fills exp_b/exp_d from src, returns output count.
    function automatic int model_fwd(input int len);
        int rows = (len + 31) / 32;
        int nd   = rows * 32 - len;
        int n    = 0;
        for (int k = 0; k < 32; k++) begin
            for (int r = 0; r < rows; r++) begin
                int p = r * 32 + ORDER[k];
                exp_d[n] = (p < nd);
                exp_b[n] = (p < nd) ? 1'b0 : src[p - nd];
                n++;
            end
        end
        return n;
    endfunction

    // Drive one frame from src and collect the output stream.
    task automatic run_frame(input bit inv, input int len, input bit gaps, input bit poke);
        gap_seen = 0;
        idle_at_last = 0;
        nout = 0;
        fork
            begin
                start_i = 1; len_i = LEN_W'(len); inverse_i = inv;
                @(negedge clk);
                start_i = 0;
                for (int i = 0; i < len; i++) begin
                    if (gaps && ($urandom % 4 == 0)) begin
                        in_valid_i = 0;
                        @(negedge clk);
                    end
                    in_valid_i = 1; in_bit_i = src[i];
                    @(negedge clk);
                end
                cyc_last = cyc;
                in_valid_i = 0;
            end
            begin
                do @(negedge clk); while (!out_valid_o);
                cyc_first = cyc;
                forever begin
                    if (!out_valid_o) gap_seen = 1;
                    else begin
                        got_b[nout] = out_bit_o;
                        got_d[nout] = out_dummy_o;
                        nout++;
                    end
                    if (out_last_o) begin
                        idle_at_last = idle_o;
                        break;
                    end
                    @(negedge clk);
                end
            end
            begin
                if (poke) begin
                    do @(negedge clk); while (!out_valid_o);
                    start_i = 1; len_i = LEN_W'(40); inverse_i = !inv;
                    in_valid_i = 1; in_bit_i = 1;
                    @(negedge clk);
                    start_i = 0; in_valid_i = 0;
                end
            end
        join
        @(negedge clk);
    endtask

    // Compare a collected stream against the expectation.
    task automatic judge(input bit inv, input int len, input int nexp);
        int bad_b = 0;
        int bad_d = 0;
        string tag = inv ? "R4" : "R3";
        check(nout == nexp, inv ? "R4 count" : "R2 count", nout, nexp);
        for (int j = 0; j < nout && j < nexp; j++) begin
            if (got_b[j] != (inv ? orig[j] : exp_b[j])) bad_b++;
            if (got_d[j] != (inv ? 1'b0 : exp_d[j]))    bad_d++;
        end
        check(bad_b == 0, {tag, " bit order"}, bad_b, 0);
        check(bad_d == 0, inv ? "R4 no dummy flag" : "R2 dummy flags", bad_d, 0);
        check(cyc_first == cyc_last + 1, "R6 first output timing", cyc_first, cyc_last + 1);
        check(!gap_seen, "R6 contiguous output", int'(gap_seen), 0);
        check(idle_at_last, "R9 idle with last output R5", int'(idle_at_last), 1);
        check(!out_valid_o && !out_last_o, "R5 nothing after last", int'(out_valid_o), 0);
        $display("len=%0d inv=%0d outputs=%0d", len, inv, nout);
    endtask

    task automatic round_trip(input int len, input bit gaps, input bit poke);
        int nexp;
        int m = 0;
        for (int i = 0; i < len; i++) begin
            src[i]  = 1'($urandom);
            orig[i] = src[i];
        end
        nexp = model_fwd(len);
        run_frame(0, len, gaps, poke);
        judge(0, len, nexp);
        for (int j = 0; j < nexp; j++) begin
            if (!exp_d[j]) begin
                src[m] = exp_b[j];
                m++;
            end
        end
        run_frame(1, len, gaps, poke);
        judge(1, len, len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        check(idle_o && !out_valid_o && !out_last_o, "R1 reset state", int'(idle_o), 1);
        rst_n = 1;
        @(negedge clk);
        check(idle_o && !out_valid_o, "R1 after reset", int'(out_valid_o), 0);

        // R7: out-of-range lengths are refused.
        start_i = 1; len_i = '0;
        @(negedge clk);
        len_i = LEN_W'(MAX_LEN + 1);
        @(negedge clk);
        start_i = 0;
        repeat (3) @(negedge clk);
        check(idle_o && !out_valid_o, "R7 bad length ignored", int'(idle_o), 1);

        // R8: stray valid while idle has no effect on the following frame.
        in_valid_i = 1; in_bit_i = 1;
        @(negedge clk);
        in_valid_i = 0;

        round_trip(44, 0, 1);
        round_trip(6148, 0, 1);
        round_trip(100, 1, 0);
        round_trip(1, 0, 0);
        round_trip(5, 0, 0);
        round_trip(32, 0, 1);
        round_trip(33, 1, 0);
        round_trip(64, 0, 0);
        for (int t = 0; t < 4; t++) begin
            round_trip(1 + int'($urandom % 700), 1, 1);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule